// File: doc/BRIEF.md
# Complementary PWM Pair With Dead Time

The block drives two PWM outputs from one shared period counter: a main output and a complementary output. The main output asks to be high in the early part of each period, below its own duty value. The complementary output asks to be high in the late part, from its own duty value onward. So the two start a period with opposite levels. Whenever the active request moves from one output to the other, both outputs are held low for a programmable number of cycles before the new output may rise. As a result the pair can never drive both sides of a half-bridge at once.

The pair is controlled through a small configuration port and one run level:

- **Configuration port.** It carries the period, one duty value per output and the dead time. A write is held in a pending set. The pending set is copied into the active set while the pair is stopped, and at the end of each period while it runs. A reconfiguration therefore never cuts a period short.
- **Run level.** It starts and stops both outputs together. Stopping clears the shared counter, so the next start begins a fresh period with a fresh dead gap.

The output controller is a four-state machine:

| State | Meaning |
|---|---|
| IDLE | Stopped |
| GAP | Both outputs low while a request settles |
| DRV_A | Main output high |
| DRV_B | Complementary output high |

Its transitions are as follows:

- **Start:** IDLE to GAP, or IDLE straight to a drive state when the dead time is zero.
- **Settle:** GAP to DRV_A or DRV_B, once a request has held long enough.
- **Release:** DRV_A or DRV_B to GAP, when the request changes.
- **Swap:** DRV_A to DRV_B or back, only with zero dead time.
- **Stop:** any state to IDLE.

Top module: `cpwm_pair`

## Requirements
- R1: While reset is asserted, and after reset while run has not yet been sampled high, out_a and out_b are both low.
- R2: out_a and out_b are never high in the same cycle.
- R3: Positions are numbered by clock edge. The first edge at which run is sampled high is position 0, and each later edge with run high is the next position. The counter value c is 0 at position 0, rises by one per position and returns to 0 after P-1, where P is the active period. At each position, the main request is true when c < duty_a and c >= duty_b is false. The complementary request is true when c >= duty_b and c < duty_a is false. Otherwise neither request is true. The outputs seen after a position's edge reflect that position.
- R4: With dead time T, an output is high after a position's edge exactly when its request has been true at that position and at the T positions just before it, all since the latest start.
- R5: A run of consecutive positions with the same request whose length is at most T gives no pulse at all on that output.
- R6: Both outputs share one period P. c wraps to 0 after P-1, and a period of 0 or 1 keeps c at 0.
- R7: A write with cfg_we high updates a pending set on that edge. The pending set is copied into the active set at every edge where run is sampled low, and at the edge that ends a position with c = P-1. Values written while running first take effect at the next position 0 that follows such a copy.
- R8: When run is sampled low at an edge, both outputs are low after that edge and stay low. The next start restarts at position 0 with c = 0 and a full dead gap.
- R9: duty_a = 0 leaves the main output never requested. duty_a >= P with duty_b >= P gives a main request at every position, so that output stays high from position T on.
- R10: With T = 0, each output follows its request at the same position, and a direct swap between outputs happens with no low cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Joint start (high) and stop (low) of the pair |
| cfg_we | input | 1 | Writes the four configuration fields into the pending set |
| cfg_period | input | CW | Shared period P in clock cycles |
| cfg_duty_a | input | CW | Main output duty: request while c < duty_a |
| cfg_duty_b | input | CW | Complementary duty: request while c >= duty_b |
| cfg_dead | input | DTW | Dead time T in clock cycles |
| out_a | output | 1 | Main output |
| out_b | output | 1 | Complementary output |

## Verification
The assertions take several things about the inputs for granted:

- The dead time never exceeds the range of the settling counter.
- The period changes only at a load.
- A configuration written on an edge is not expected in the active set before the next edge.

The stimulus keeps within these limits as follows:

- Every pending set is written while the pair is stopped, and run is raised only after at least two more edges.
- Dead times stay within the field width.
- Running reconfiguration is issued at a single, chosen position.
- The bench model applies the write only at a period end that comes at least two edges later, which matches when the pending set can actually be copied.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Output controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_DRV_A = 2'd2,
        ST_DRV_B = 2'd3
    } pair_state_t;

    // Which output the current counter position asks for
    typedef enum logic [1:0] {
        WANT_NONE = 2'd0,
        WANT_A    = 2'd1,
        WANT_B    = 2'd2
    } want_t;

endpackage

// File: rtl/cpwm_cfg_bank.sv
module cpwm_cfg_bank #(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_period,
    input  logic [CW-1:0]  wr_duty_a,
    input  logic [CW-1:0]  wr_duty_b,
    input  logic [DTW-1:0] wr_dead,
    input  logic           take,
    output logic [CW-1:0]  per_q,
    output logic [CW-1:0]  duty_a_q,
    output logic [CW-1:0]  duty_b_q,
    output logic [DTW-1:0] dead_q
);

    logic [CW-1:0]  per_p, duty_a_p, duty_b_p;
    logic [DTW-1:0] dead_p;

    // pending set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_p    <= '0;
            duty_a_p <= '0;
            duty_b_p <= '0;
            dead_p   <= '0;
        end else if (wr_en) begin
            per_p    <= wr_period;
            duty_a_p <= wr_duty_a;
            duty_b_p <= wr_duty_b;
            dead_p   <= wr_dead;
        end
    end

    // active set, copied only when stopped or at a period end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q    <= '0;
            duty_a_q <= '0;
            duty_b_q <= '0;
            dead_q   <= '0;
        end else if (take) begin
            per_q    <= per_p;
            duty_a_q <= duty_a_p;
            duty_b_q <= duty_b_p;
            dead_q   <= dead_p;
        end
    end

endmodule

// File: rtl/cpwm_ramp.sv
module cpwm_ramp #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW:0] STEP = (CW+1)'(1);

    logic [CW:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt} + STEP;
    assign last    = cnt_inc >= {1'b0, period};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[CW-1:0];
        end
    end

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) || (cnt < period));

endmodule

// File: rtl/cpwm_gap_fsm.sv
module cpwm_gap_fsm
    import cpwm_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [CW-1:0]  cnt,
    input  logic [CW-1:0]  duty_a,
    input  logic [CW-1:0]  duty_b,
    input  logic [DTW-1:0] dead,
    output logic           out_a,
    output logic           out_b
);

    localparam logic [DTW-1:0] AGE_MAX = '1;

    pair_state_t    state_q, state_d, pick;
    want_t          want, want_q;
    logic [DTW-1:0] age_q, age_d;
    logic           ref_a, ref_b, settled;

    // request decode from the shared counter
    always_comb begin
        ref_a = cnt < duty_a;
        ref_b = cnt >= duty_b;
        unique case ({ref_a, ref_b})
            2'b10:   want = WANT_A;
            2'b01:   want = WANT_B;
            default: want = WANT_NONE;
        endcase
    end

    // how long the current request has held, saturating
    always_comb begin
        if (state_q != ST_IDLE && want == want_q) begin
            age_d = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;
        end else begin
            age_d = '0;
        end
        settled = age_d >= dead;
        if (want == WANT_A && settled) begin
            pick = ST_DRV_A;
        end else if (want == WANT_B && settled) begin
            pick = ST_DRV_B;
        end else begin
            pick = ST_GAP;
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = run ? pick : ST_IDLE;
            ST_GAP:   state_d = run ? pick : ST_IDLE;
            ST_DRV_A: state_d = run ? pick : ST_IDLE;
            ST_DRV_B: state_d = run ? pick : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            want_q  <= WANT_NONE;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            want_q  <= want;
            age_q   <= age_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DRV_A: begin out_a = 1'b1; out_b = 1'b0; end
            ST_DRV_B: begin out_a = 1'b0; out_b = 1'b1; end
            default:  begin out_a = 1'b0; out_b = 1'b0; end
        endcase
    end

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    // R4
    gap_before_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_a) && $past(dead) != '0) |-> !$past(out_b));

    // R4
    gap_before_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_b) && $past(dead) != '0) |-> !$past(out_a));

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           cfg_we,
    input  logic [CW-1:0]  cfg_period,
    input  logic [CW-1:0]  cfg_duty_a,
    input  logic [CW-1:0]  cfg_duty_b,
    input  logic [DTW-1:0] cfg_dead,
    output logic           out_a,
    output logic           out_b
);

    logic [CW-1:0]  per_q, duty_a_q, duty_b_q, cnt;
    logic [DTW-1:0] dead_q;
    logic           last, take;

    assign take = !run || last;

    cpwm_cfg_bank #(.CW(CW), .DTW(DTW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_period (cfg_period),
        .wr_duty_a (cfg_duty_a),
        .wr_duty_b (cfg_duty_b),
        .wr_dead   (cfg_dead),
        .take      (take),
        .per_q     (per_q),
        .duty_a_q  (duty_a_q),
        .duty_b_q  (duty_b_q),
        .dead_q    (dead_q)
    );

    cpwm_ramp #(.CW(CW)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (per_q),
        .cnt    (cnt),
        .last   (last)
    );

    cpwm_gap_fsm #(.CW(CW), .DTW(DTW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cnt    (cnt),
        .duty_a (duty_a_q),
        .duty_b (duty_b_q),
        .dead   (dead_q),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!out_a && !out_b));

    // R7
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && cnt != '0) |->
        ($stable(per_q) && $stable(duty_a_q) && $stable(duty_b_q) && $stable(dead_q)));

endmodule

// File: tb/sim_cpwm_pair.sv
`timescale 1ns/1ps
module sim_cpwm_pair;

    localparam int CW  = 8;
    localparam int DTW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           run = 1'b0;
    logic           cfg_we = 1'b0;
    logic [CW-1:0]  cfg_period = '0;
    logic [CW-1:0]  cfg_duty_a = '0;
    logic [CW-1:0]  cfg_duty_b = '0;
    logic [DTW-1:0] cfg_dead = '0;
    logic           out_a, out_b;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cpwm_pair #(.CW(CW), .DTW(DTW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg_we     (cfg_we),
        .cfg_period (cfg_period),
        .cfg_duty_a (cfg_duty_a),
        .cfg_duty_b (cfg_duty_b),
        .cfg_dead   (cfg_dead),
        .out_a      (out_a),
        .out_b      (out_b)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0b exp=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // 0 none, 1 main, 2 complementary
    function automatic int want_of(int c, int da, int db);
        bit ra = c < da;
        bit rb = c >= db;
        if (ra && !rb) return 1;
        if (rb && !ra) return 2;
        return 0;
    endfunction

    task automatic drive_cfg(int p, int da, int db, int t);
        cfg_period = p[CW-1:0];
        cfg_duty_a = da[CW-1:0];
        cfg_duty_b = db[CW-1:0];
        cfg_dead   = t[DTW-1:0];
        cfg_we     = 1'b1;
    endtask

    // R8: joint stop, both outputs low and staying low
    task automatic stop_check();
        run = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8", "out_a after stop", out_a, 1'b0);
        chk("R8", "out_b after stop", out_b, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8", "out_a held stopped", out_a, 1'b0);
        chk("R8", "out_b held stopped", out_b, 1'b0);
    endtask

    task automatic run_case(input string tag, input int p, input int da, input int db, input int t,
                            input int n, input int wk, input int np, input int nda,
                            input int ndb, input int nt);
        int ap = p, ada = da, adb = db, at = t;
        int pp = 0, pda = 0, pdb = 0, pt = 0;
        bit pend = 0;
        int pend_from = 0;
        int c = 0, age = 0, tg = 0, tg_prev = 0;
        bit ea, eb;
        drive_cfg(p, da, db, t);
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                if (c + 1 >= ap) begin
                    if (pend && (k - 1) >= pend_from) begin
                        ap = pp; ada = pda; adb = pdb; at = pt; pend = 0;
                    end
                    c = 0;
                end else begin
                    c = c + 1;
                end
            end
            tg = want_of(c, ada, adb);
            age = (k > 0 && tg == tg_prev) ? age + 1 : 0;
            tg_prev = tg;
            ea = (tg == 1) && (age >= at);
            eb = (tg == 2) && (age >= at);
            @(posedge clk); @(negedge clk);
            chk(tag, $sformatf("out_a p=%0d c=%0d da=%0d db=%0d t=%0d", ap, c, ada, adb, at), out_a, ea);
            chk(tag, $sformatf("out_b p=%0d c=%0d da=%0d db=%0d t=%0d", ap, c, ada, adb, at), out_b, eb);
            chk("R2", "no overlap", out_a & out_b, 1'b0);
            if (k == wk) begin
                drive_cfg(np, nda, ndb, nt);
                pend = 1; pend_from = k + 2;
                pp = np; pda = nda; pdb = ndb; pt = nt;
            end else begin
                cfg_we = 1'b0;
            end
        end
        cfg_we = 1'b0;
        stop_check();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "out_a in reset", out_a, 1'b0);
        chk("R1", "out_b in reset", out_b, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "out_a idle after reset", out_a, 1'b0);
        chk("R1", "out_b idle after reset", out_b, 1'b0);

        // R3: every duty pairing over a small period
        for (int da = 0; da <= 6; da++)
            for (int db = 0; db <= 6; db++)
                run_case("R3", 6, da, db, 1, 18, -1, 0, 0, 0, 0);

        // R4 and R10: dead-time sweep with matched duties
        for (int t = 0; t <= 3; t++)
            for (int d = 1; d <= 5; d++)
                run_case((t == 0) ? "R10" : "R4", 6, d, d, t, 18, -1, 0, 0, 0, 0);
        run_case("R10", 4, 2, 1, 0, 12, -1, 0, 0, 0, 0);

        // R5: pulses no longer than the dead time vanish
        run_case("R5", 8, 3, 3, 3, 24, -1, 0, 0, 0, 0);
        run_case("R5", 8, 3, 3, 5, 24, -1, 0, 0, 0, 0);
        run_case("R5", 8, 2, 2, 7, 24, -1, 0, 0, 0, 0);
        run_case("R5", 5, 2, 2, 15, 40, -1, 0, 0, 0, 0);

        // R9: extreme duty values
        run_case("R9", 5, 0, 0, 2, 15, -1, 0, 0, 0, 0);
        run_case("R9", 5, 5, 5, 2, 15, -1, 0, 0, 0, 0);
        run_case("R9", 5, 9, 9, 0, 15, -1, 0, 0, 0, 0);

        // R6: period sweep, including degenerate period
        for (int p = 2; p <= 9; p++)
            run_case("R6", p, p / 2, p / 2, 1, 3 * p + 2, -1, 0, 0, 0, 0);
        run_case("R6", 1, 1, 1, 0, 6, -1, 0, 0, 0, 0);
        run_case("R6", 0, 1, 1, 0, 6, -1, 0, 0, 0, 0);

        // R7: running reconfiguration waits for the period end
        run_case("R7", 6, 2, 2, 1, 30, 4, 4, 3, 3, 0);
        run_case("R7", 6, 4, 4, 2, 30, 5, 9, 3, 6, 1);
        run_case("R7", 7, 3, 3, 1, 30, 0, 5, 1, 4, 2);
        run_case("R7", 5, 2, 2, 1, 30, 3, 5, 4, 4, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog all-reqs got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule